// File: doc/BRIEF.md
# Ethernet Receive Address and Length Filter

This block makes the keep-or-discard decision for every frame that arrives at an Ethernet receiver. The receive front end pulses a frame-end strobe once the frame has been fully received. In that same cycle it presents the header and trailer facts it has already extracted: the 48-bit destination address, the byte count, the CRC check result, a bus-error indication, and a 6-bit hash bin index. The bin index is the top six bits of the CRC-32 taken over the destination address, and it is computed outside this block.

Using the station address, a 64-bin multicast hash table and a set of enables, the filter registers a single result one clock later. That result is an accept bit, a status word with the classification flags and the length, and a combined error bit. A valid pulse lasting one cycle marks the result. Promiscuous mode accepts every frame. Separate enables let short frames, oversize frames and multicast traffic through.

Top module: `rx_frame_filter`

## Requirements
- R1: The result appears in the clock cycle after `frameEnd`. `outValid` is high for exactly that one cycle. When `frameEnd` is low, `outAccept`, `outStatus` and `outErr` keep their previous values. During reset, `outValid`, `outAccept` and `outStatus` are all 0.
- R2: A frame is unicast-matched when `destAddr` equals `{staHi, staLo}`. A unicast-matched frame is accepted unless R6, R7 or R8 drop it.
- R3: A destination of all ones is broadcast. Broadcast sets status bit 12, and the frame is address-accepted only when `enBcast` is 1.
- R4: A destination is multicast when `destAddr[40]` is 1 and the address is not all ones. Multicast sets status bit 11. With `enMcast` at 1 the frame is address-accepted. With `enMcast` at 0 it is address-accepted only when `enHash` is 1 and the bin selected by `hashIdx` is set. Bins 0 to 31 are `hashLo[hashIdx]` and bins 32 to 63 are `hashHi[hashIdx-32]`.
- R5: A unicast destination that does not match the station address is dropped.
- R6: A length below 64 is a runt. A runt sets status bit 15 and is dropped unless `enRunt` is 1.
- R7: A length above 1518 is too long. Such a frame sets status bit 14 and is dropped unless `enLong` is 1. Lengths of exactly 64 and exactly 1518 are not flagged.
- R8: `crcErr` sets status bit 13, and the frame is dropped.
- R9: When `rxAll` is 1, every frame is accepted, overriding R3 to R8. All flags are still reported.
- R10: Status bits 10:0 carry the length. Bit 16 reports `busErr`, which does not change the accept decision. `outErr` is the OR of status bits 16 down to 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameEnd | input | 1 | One-cycle strobe at the end of a received frame |
| destAddr | input | 48 | Destination address; the first octet sits in bits 47:40 |
| frameLen | input | 11 | Frame length in bytes |
| crcErr | input | 1 | The frame failed its CRC check |
| busErr | input | 1 | A bus error occurred while the frame was stored |
| hashIdx | input | 6 | Hash bin (top six bits of the CRC-32 of the destination) |
| staLo | input | 32 | Station address bits 31:0 |
| staHi | input | 16 | Station address bits 47:32 |
| hashLo | input | 32 | Hash bins 0 to 31 |
| hashHi | input | 32 | Hash bins 32 to 63 |
| enBcast | input | 1 | Accept broadcast frames |
| enMcast | input | 1 | Accept all multicast frames |
| enHash | input | 1 | Accept multicast frames whose hash bin is set |
| rxAll | input | 1 | Promiscuous mode |
| enRunt | input | 1 | Accept frames shorter than 64 bytes |
| enLong | input | 1 | Accept frames longer than 1518 bytes |
| outValid | output | 1 | The result is valid in this cycle |
| outAccept | output | 1 | The frame is accepted |
| outStatus | output | 17 | Flags and length (see R3 to R10) |
| outErr | output | 1 | At least one error flag is set |

## Verification
The bench uses the default parameters. These are an 11-bit length, limits of 64 and 1518 bytes, a 48-bit address and a 6-bit hash index. With an 11-bit length, lengths above 1518 up to 2047 can be driven, so both sides of each length boundary get exercised. The 6-bit index reaches bins in both halves of the hash table. Directed frames cover each boundary, and a randomized stream is then compared against a behavioural model on every frame. That stream draws station-address matches, broadcasts, multicasts and foreign unicasts under random enables.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  // Classification produced by the datapath for the frame in hand
  typedef struct packed {
    logic ownHit;
    logic bcast;
    logic mcast;
    logic hashHit;
    logic runt;
    logic tooLong;
  } rxClass_t;

  // Strobes from control into the datapath
  typedef struct packed {
    logic load;
    logic accept;
  } rxStrobe_t;

  // Flag part of the status word, MSB first
  typedef struct packed {
    logic busErr;
    logic runt;
    logic tooLong;
    logic crcErr;
    logic bcast;
    logic mcast;
  } rxFlags_t;

  localparam int FLAG_W = 6;

endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
(
  input  logic      frameEnd,
  input  rxClass_t  cls,
  input  logic      crcErr,
  input  logic      enBcast,
  input  logic      enMcast,
  input  logic      enHash,
  input  logic      rxAll,
  input  logic      enRunt,
  input  logic      enLong,
  output rxStrobe_t strobe
);

  logic addrOk;
  logic sizeOk;

  always_comb begin
    addrOk = cls.ownHit
           | (cls.bcast & enBcast)
           | (cls.mcast & (enMcast | (enHash & cls.hashHit)));
    sizeOk = (~cls.runt | enRunt) & (~cls.tooLong | enLong);
    strobe.load   = frameEnd;
    strobe.accept = rxAll | (addrOk & sizeOk & ~crcErr);
  end

endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1518,
  parameter int HASH_BITS = 6,
  localparam int HASH_SZ  = 1 << HASH_BITS,
  localparam int STAT_W   = LEN_W + FLAG_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    destAddr,
  input  logic [LEN_W-1:0]     frameLen,
  input  logic                 crcErr,
  input  logic                 busErr,
  input  logic [HASH_BITS-1:0] hashIdx,
  input  logic [ADDR_W-1:0]    staAddr,
  input  logic [HASH_SZ-1:0]   hashTable,
  input  rxStrobe_t            strobe,
  output rxClass_t             cls,
  output logic                 validQ,
  output logic                 acceptQ,
  output logic [STAT_W-1:0]    statusQ,
  output logic                 errQ
);

  localparam int GRP_BIT = ADDR_W - 8;
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_LEN);

  logic     allOnes;
  rxFlags_t flagsD;
  rxFlags_t flagsQ;

  always_comb begin
    allOnes     = &destAddr;
    cls.ownHit  = (destAddr == staAddr);
    cls.bcast   = allOnes;
    cls.mcast   = destAddr[GRP_BIT] & ~allOnes;
    cls.hashHit = hashTable[hashIdx];
    cls.runt    = (frameLen < MIN_L);
    cls.tooLong = (frameLen > MAX_L);

    flagsD.busErr  = busErr;
    flagsD.runt    = cls.runt;
    flagsD.tooLong = cls.tooLong;
    flagsD.crcErr  = crcErr;
    flagsD.bcast   = cls.bcast;
    flagsD.mcast   = cls.mcast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      acceptQ <= 1'b0;
      statusQ <= '0;
    end else begin
      validQ <= strobe.load;
      if (strobe.load) begin
        acceptQ <= strobe.accept;
        statusQ <= {flagsD, frameLen};
      end
    end
  end

  always_comb begin
    flagsQ = rxFlags_t'(statusQ[STAT_W-1:LEN_W]);
    errQ   = flagsQ.busErr | flagsQ.runt | flagsQ.tooLong | flagsQ.crcErr;
  end

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int LEN_W     = 11,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 1518,
  parameter int HASH_BITS = 6,
  localparam int HASH_SZ  = 1 << HASH_BITS,
  localparam int STAT_W   = LEN_W + FLAG_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 frameEnd,
  input  logic [ADDR_W-1:0]    destAddr,
  input  logic [LEN_W-1:0]     frameLen,
  input  logic                 crcErr,
  input  logic                 busErr,
  input  logic [HASH_BITS-1:0] hashIdx,
  input  logic [31:0]          staLo,
  input  logic [ADDR_W-33:0]   staHi,
  input  logic [HASH_SZ/2-1:0] hashLo,
  input  logic [HASH_SZ/2-1:0] hashHi,
  input  logic                 enBcast,
  input  logic                 enMcast,
  input  logic                 enHash,
  input  logic                 rxAll,
  input  logic                 enRunt,
  input  logic                 enLong,
  output logic                 outValid,
  output logic                 outAccept,
  output logic [STAT_W-1:0]    outStatus,
  output logic                 outErr
);

  rxClass_t  cls;
  rxStrobe_t strobe;

  rxf_ctrl u_ctrl (
    .frameEnd (frameEnd),
    .cls      (cls),
    .crcErr   (crcErr),
    .enBcast  (enBcast),
    .enMcast  (enMcast),
    .enHash   (enHash),
    .rxAll    (rxAll),
    .enRunt   (enRunt),
    .enLong   (enLong),
    .strobe   (strobe)
  );

  rxf_datapath #(
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W),
    .MIN_LEN   (MIN_LEN),
    .MAX_LEN   (MAX_LEN),
    .HASH_BITS (HASH_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .destAddr  (destAddr),
    .frameLen  (frameLen),
    .crcErr    (crcErr),
    .busErr    (busErr),
    .hashIdx   (hashIdx),
    .staAddr   ({staHi, staLo}),
    .hashTable ({hashHi, hashLo}),
    .strobe    (strobe),
    .cls       (cls),
    .validQ    (outValid),
    .acceptQ   (outAccept),
    .statusQ   (outStatus),
    .errQ      (outErr)
  );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int ADDR_W  = 48,
  parameter int LEN_W   = 11,
  parameter int MIN_LEN = 64,
  parameter int STAT_W  = 17
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameEnd,
  input logic [ADDR_W-1:0] destAddr,
  input logic [ADDR_W-1:0] staAddr,
  input logic [LEN_W-1:0]  frameLen,
  input logic              crcErr,
  input logic              rxAll,
  input logic              enRunt,
  input logic              outValid,
  input logic              outAccept,
  input logic [STAT_W-1:0] outStatus
);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> outValid);

  a_r1_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> !outValid);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> ($stable(outStatus) && $stable(outAccept)));

  a_r10_length: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> (outStatus[LEN_W-1:0] == $past(frameLen)));

  a_r9_promisc: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && rxAll) |=> outAccept);

  a_r8_crc_drop: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && crcErr && !rxAll) |=> (!outAccept && outStatus[LEN_W+2]));

  a_r6_runt_drop: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && (int'(frameLen) < MIN_LEN) && !enRunt && !rxAll)
      |=> (!outAccept && outStatus[LEN_W+4]));

  a_r5_foreign_drop: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && !destAddr[ADDR_W-8] && (destAddr != staAddr) && !rxAll)
      |=> !outAccept);

endmodule

bind rx_frame_filter rxf_checker #(
  .ADDR_W  (ADDR_W),
  .LEN_W   (LEN_W),
  .MIN_LEN (MIN_LEN),
  .STAT_W  (STAT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .frameEnd  (frameEnd),
  .destAddr  (destAddr),
  .staAddr   ({staHi, staLo}),
  .frameLen  (frameLen),
  .crcErr    (crcErr),
  .rxAll     (rxAll),
  .enRunt    (enRunt),
  .outValid  (outValid),
  .outAccept (outAccept),
  .outStatus (outStatus)
);

// File: tb/rx_frame_filter_tb.sv
`timescale 1ns/1ps
module rx_frame_filter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameEnd = 1'b0;
  logic [47:0] destAddr = '0;
  logic [10:0] frameLen = '0;
  logic        crcErr = 1'b0;
  logic        busErr = 1'b0;
  logic [5:0]  hashIdx = '0;
  logic [31:0] staLo = 32'h3344_5566;
  logic [15:0] staHi = 16'h0211;
  logic [31:0] hashLo = 32'h0000_0020;
  logic [31:0] hashHi = 32'h0000_0100;
  logic        enBcast = 1'b0, enMcast = 1'b0, enHash = 1'b0;
  logic        rxAll = 1'b0, enRunt = 1'b0, enLong = 1'b0;
  logic        outValid, outAccept, outErr;
  logic [16:0] outStatus;

  int nTests = 0;
  int nFails = 0;
  logic [17:0] lastRes = '0;

  always #4 clk = ~clk;

  rx_frame_filter u_dut (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .destAddr(destAddr),
    .frameLen(frameLen), .crcErr(crcErr), .busErr(busErr), .hashIdx(hashIdx),
    .staLo(staLo), .staHi(staHi), .hashLo(hashLo), .hashHi(hashHi),
    .enBcast(enBcast), .enMcast(enMcast), .enHash(enHash), .rxAll(rxAll),
    .enRunt(enRunt), .enLong(enLong), .outValid(outValid),
    .outAccept(outAccept), .outStatus(outStatus), .outErr(outErr)
  );

  // Behavioural model: {accept, status[16:0]}
  function automatic logic [17:0] refModel();
    bit bc, mc, own, rn, lg, hb, addr, acc;
    int idx;
    logic [16:0] st;
    bc  = (destAddr == 48'hFFFF_FFFF_FFFF);
    mc  = destAddr[40] && !bc;
    own = (destAddr == {staHi, staLo});
    rn  = (int'(frameLen) < 64);
    lg  = (int'(frameLen) > 1518);
    idx = int'(hashIdx);
    hb  = (idx < 32) ? hashLo[idx] : hashHi[idx - 32];
    addr = own || (bc && enBcast) || (mc && (enMcast || (enHash && hb)));
    acc  = rxAll || (addr && (!rn || enRunt) && (!lg || enLong) && !crcErr);
    st = {busErr, rn, lg, crcErr, bc, mc, frameLen};
    return {acc, st};
  endfunction

  task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Call at a negedge; drives a frame-end and checks the result one cycle on
  task automatic frame(string tag, logic [47:0] d, int len, bit crc, bit bus, int idx);
    logic [17:0] e;
    destAddr = d; frameLen = 11'(len); crcErr = crc; busErr = bus;
    hashIdx = 6'(idx); frameEnd = 1'b1;
    e = refModel();
    @(negedge clk);
    frameEnd = 1'b0;
    check(tag, {outValid, outAccept, outStatus, outErr},
          {1'b1, e, |e[16:13]});
    lastRes = e;
  endtask

  task automatic idle(string tag);
    @(negedge clk);
    check(tag, {outValid, outAccept, outStatus, outErr},
          {1'b0, lastRes, |lastRes[16:13]});
  endtask

  localparam logic [47:0] OWN  = 48'h0211_3344_5566;
  localparam logic [47:0] FORN = 48'h0211_3344_5567;
  localparam logic [47:0] BCST = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] MCST = 48'h0100_5E00_0001;

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", {outValid, outAccept, outStatus, outErr}, 20'h0);
    rstN = 1'b1;
    @(negedge clk);

    frame("R2 own unicast", OWN, 100, 0, 0, 0);
    frame("R5 foreign unicast", FORN, 100, 0, 0, 0);
    idle("R1 hold after frame");
    frame("R3 bcast disabled", BCST, 200, 0, 0, 0);
    enBcast = 1'b1;
    frame("R3 bcast enabled", BCST, 200, 0, 0, 0);
    enMcast = 1'b1;
    frame("R4 mcast enabled", MCST, 80, 0, 0, 7);
    enMcast = 1'b0;
    frame("R4 mcast no hash", MCST, 80, 0, 0, 5);
    enHash = 1'b1;
    frame("R4 hash low bin set", MCST, 80, 0, 0, 5);
    frame("R4 hash low bin clear", MCST, 80, 0, 0, 6);
    frame("R4 hash high bin set", MCST, 80, 0, 0, 40);
    frame("R4 hash high bin clear", MCST, 80, 0, 0, 41);
    frame("R6 runt 63", OWN, 63, 0, 0, 0);
    frame("R6 len 64", OWN, 64, 0, 0, 0);
    enRunt = 1'b1;
    frame("R6 runt accepted", OWN, 10, 0, 0, 0);
    frame("R7 len 1518", OWN, 1518, 0, 0, 0);
    frame("R7 long 1519", OWN, 1519, 0, 0, 0);
    enLong = 1'b1;
    frame("R7 long accepted", OWN, 2047, 0, 0, 0);
    frame("R8 crc error", OWN, 500, 1, 0, 0);
    rxAll = 1'b1;
    frame("R9 promisc crc", OWN, 500, 1, 0, 0);
    enRunt = 1'b0; enLong = 1'b0;
    frame("R9 promisc foreign runt", FORN, 5, 0, 0, 0);
    rxAll = 1'b0;
    frame("R10 bus error", OWN, 300, 0, 1, 0);
    idle("R1 hold idle");

    for (int i = 0; i < 400; i++) begin
      int sel, ln;
      sel = int'($urandom_range(0, 3));
      case (sel)
        0: destAddr = OWN;
        1: destAddr = BCST;
        2: destAddr = {8'h01 | 8'($urandom), 8'($urandom), 32'($urandom)};
        default: destAddr = {8'hFE & 8'($urandom), 8'($urandom), 32'($urandom)};
      endcase
      case ($urandom_range(0, 2))
        0: ln = int'($urandom_range(60, 68));
        1: ln = int'($urandom_range(1514, 1522));
        default: ln = int'($urandom_range(0, 2047));
      endcase
      {enBcast, enMcast, enHash, enRunt, enLong} = 5'($urandom);
      rxAll = ($urandom_range(0, 7) == 0);
      hashLo = $urandom; hashHi = $urandom;
      frame("R2-R10 random", destAddr, ln, ($urandom_range(0, 5) == 0),
            ($urandom_range(0, 7) == 0), int'($urandom_range(0, 63)));
      if ($urandom_range(0, 3) == 0) idle("R1 random idle");
    end

    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    nTests++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule